// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers four interrupt causes for a small 8-bit processor core and turns them into a single request with a vector address. The causes are a level change on a group of watched port bits, a selectable edge on one external port bit, a timer overflow pulse and an A/D-complete pulse. Each cause has a sticky flag and its own enable. The A/D cause sits behind an extra peripheral enable. A global enable gates all four.

The processor reads and writes three byte-wide registers through a simple select/strobe interface. The first is a control/status byte that holds three flags and five enables. The other two are a peripheral flag byte and a peripheral enable byte. When the processor accepts a request, the block drops the global enable so that handlers do not nest. The return-from-interrupt strobe raises the global enable again.

Top module: `intr_flag_ctl`

## Requirements
- R1: After reset, all three registers read 00h, `irq_req` is 0 and `irq_vector` is 000h.
- R2: Register selects are 0 for control/status, 1 for peripheral flags, 2 for peripheral enables, and 3 for none. All 8 bits of the control/status byte can be written and read back. In the peripheral bytes only bit 6 is stored, and the other bits read 0. Select 3 reads 00h and ignores writes.
- R3: Control/status bit 0 (pin-change flag) is set when port bits 0, 1 or 3 differ from the snapshot of those bits taken on the last `port_rd` strobe. The comparison in the strobe cycle uses the old snapshot. Changes on any other port bit have no effect.
- R4: Control/status bit 1 (external flag) is set by an edge on port bit 2. The edge is falling when `ext_rise_sel` is 0 and rising when it is 1. The opposite edge is ignored.
- R5: A `tmr_ovf` pulse sets control/status bit 2 at the next clock edge.
- R6: An `adc_done` pulse sets bit 6 of the peripheral flag byte at the next clock edge.
- R7: Flags are set whatever the state of their enables. Only a register write clears a flag. If a hardware set and a write of 0 fall in the same cycle, the set wins.
- R8: `irq_req` is high when control/status bit 7 (global enable) is 1 and at least one source is pending. The sources are bit0&bit3, bit1&bit4, bit2&bit5, and the A/D flag with its enable when bit 6 (peripheral enable) is also 1.
- R9: `irq_vector` is 004h while `irq_req` is high and 000h otherwise.
- R10: `int_ack` clears the global enable at the next edge. This overrides a same-cycle register write or `int_ret`.
- R11: `int_ret` sets the global enable at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| port_in | input | PORT_W | Port pin levels |
| port_rd | input | 1 | Port read strobe, refreshes the change snapshot |
| ext_rise_sel | input | 1 | External edge select: 1 rising, 0 falling |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | A/D-complete pulse |
| int_ack | input | 1 | Processor accepts the request |
| int_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | ADDR_W | Vector address |

## Verification
The hardest case to reach from the ports is a collision between a hardware flag set and a software clear in the same cycle. A related case is the pin-change flag re-arming while the port still differs from a stale snapshot. The stimulus table reaches both. It holds the port at a new value while writing 0 to the flag, and it issues the `port_rd` strobe in that same cycle. Later steps show that the flag only stays clear once the snapshot matches. The acknowledge-versus-return collision is reached the same way: `int_ack`, `int_ret` and a write of 1 to the global enable are driven together.

// File: rtl/ifc_pkg.sv
// Package: shared register selects and bit positions for the interrupt
// flag and enable controller. Assumes an 8-bit register width.
package ifc_pkg;
    typedef enum logic [1:0] {
        RSEL_CTRL  = 2'd0,
        RSEL_PFLAG = 2'd1,
        RSEL_PEN   = 2'd2,
        RSEL_NONE  = 2'd3
    } rsel_e;

    localparam int REG_W    = 8;
    localparam int NSRC     = 3;   // sources with flag/enable pairs in the control byte
    localparam int EN_BASE  = 3;   // enable of source i sits at bit EN_BASE+i
    localparam int PEIE_BIT = 6;
    localparam int GIE_BIT  = 7;
    localparam int ADC_BIT  = 6;   // bit position in the peripheral bytes
endpackage

// File: rtl/ifc_src_detect.sv
// Module: ifc_src_detect
// Detects the two port-derived causes. The pin-change hit compares the
// watched bits against a snapshot taken on each port read strobe. The edge
// hit watches one port bit against its previous sample.
// Assumes port_in is already synchronous to clk.
module ifc_src_detect #(
    parameter int             PORT_W   = 8,
    parameter logic [PORT_W-1:0] CHG_MASK = 8'b0000_1011,
    parameter int             EXT_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              rise_sel,
    output logic              chg_hit,
    output logic              ext_hit
);
    logic [PORT_W-1:0] snap_q;
    logic              prev_q;
    logic              cur;

    assign cur = port_in[EXT_BIT];

    // Refresh the watched-bit snapshot on every port read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (port_rd) snap_q <= port_in & CHG_MASK;
    end

    // Keep the previous level of the edge pin.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // Mismatch against the old snapshot and the selected-edge decode.
    always_comb begin
        chg_hit = ((port_in & CHG_MASK) != snap_q);
        ext_hit = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);
    end
endmodule

// File: rtl/ifc_regs.sv
// Module: ifc_regs
// Holds the control/status byte and the single-bit peripheral flag and
// enable. Hardware sets take priority over software writes. Acknowledge
// takes priority over return and writes for the global enable.
module ifc_regs
    import ifc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rsel_e            wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NSRC-1:0]  src_set,
    input  logic             adc_done,
    input  logic             int_ack,
    input  logic             int_ret,
    output logic [REG_W-1:0] ctrl_q,
    output logic             pflag_q,
    output logic             pen_q
);
    logic [REG_W-1:0] ctrl_d;
    logic             pflag_d;
    logic             pen_d;

    // Next value of the control byte: write, then sticky sets, then enable control.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_sel == RSEL_CTRL) ctrl_d = wr_data;
        for (int i = 0; i < NSRC; i++) begin
            if (src_set[i]) ctrl_d[i] = 1'b1;
        end
        if (int_ret) ctrl_d[GIE_BIT] = 1'b1;
        if (int_ack) ctrl_d[GIE_BIT] = 1'b0;
    end

    // Next value of the peripheral flag and enable bits.
    always_comb begin
        pflag_d = pflag_q;
        pen_d   = pen_q;
        if (wr_en && wr_sel == RSEL_PFLAG) pflag_d = wr_data[ADC_BIT];
        if (wr_en && wr_sel == RSEL_PEN)   pen_d   = wr_data[ADC_BIT];
        if (adc_done)                      pflag_d = 1'b1;
    end

    // Register state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            pflag_q <= 1'b0;
            pen_q   <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            pflag_q <= pflag_d;
            pen_q   <= pen_d;
        end
    end
endmodule

// File: rtl/ifc_arbiter.sv
// Module: ifc_arbiter
// Combines flag/enable pairs through the peripheral and global gates into a
// request, and picks the vector address. Purely combinational.
module ifc_arbiter
    import ifc_pkg::*;
#(
    parameter int              ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] VEC_INT = 10'h004,
    parameter logic [ADDR_W-1:0] VEC_RST = 10'h000
) (
    input  logic [REG_W-1:0]  ctrl_q,
    input  logic              pflag_q,
    input  logic              pen_q,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vector
);
    logic [NSRC-1:0] pair_hit;
    logic            periph_hit;

    // One pending term per flag/enable pair in the control byte.
    for (genvar g = 0; g < NSRC; g++) begin : g_pair
        assign pair_hit[g] = ctrl_q[g] & ctrl_q[EN_BASE+g];
    end

    // Peripheral term, the global gate and the vector choice.
    always_comb begin
        periph_hit = pflag_q & pen_q & ctrl_q[PEIE_BIT];
        irq_req    = ctrl_q[GIE_BIT] & ((|pair_hit) | periph_hit);
        irq_vector = irq_req ? VEC_INT : VEC_RST;
    end
endmodule

// File: rtl/intr_flag_ctl.sv
// Module: intr_flag_ctl (top)
// Interrupt flag and enable controller: source detection, register file,
// request/vector logic and the register read multiplexer.
// Assumes all inputs are synchronous to clk.
module intr_flag_ctl
    import ifc_pkg::*;
#(
    parameter int              PORT_W   = 8,
    parameter logic [PORT_W-1:0] CHG_MASK = 8'b0000_1011,
    parameter int              EXT_BIT  = 2,
    parameter int              ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] VEC_INT  = 10'h004,
    parameter logic [ADDR_W-1:0] VEC_RST  = 10'h000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_sel,
    output logic [7:0]        rd_data,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              ext_rise_sel,
    input  logic              tmr_ovf,
    input  logic              adc_done,
    input  logic              int_ack,
    input  logic              int_ret,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vector
);
    logic             chg_hit;
    logic             ext_hit;
    logic [REG_W-1:0] ctrl_q;
    logic             pflag_q;
    logic             pen_q;
    logic [NSRC-1:0]  src_set;

    assign src_set = {tmr_ovf, ext_hit, chg_hit};

    ifc_src_detect #(.PORT_W(PORT_W), .CHG_MASK(CHG_MASK), .EXT_BIT(EXT_BIT)) det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_in  (port_in),
        .port_rd  (port_rd),
        .rise_sel (ext_rise_sel),
        .chg_hit  (chg_hit),
        .ext_hit  (ext_hit)
    );

    ifc_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (rsel_e'(wr_sel)),
        .wr_data  (wr_data),
        .src_set  (src_set),
        .adc_done (adc_done),
        .int_ack  (int_ack),
        .int_ret  (int_ret),
        .ctrl_q   (ctrl_q),
        .pflag_q  (pflag_q),
        .pen_q    (pen_q)
    );

    ifc_arbiter #(.ADDR_W(ADDR_W), .VEC_INT(VEC_INT), .VEC_RST(VEC_RST)) arb_i (
        .ctrl_q     (ctrl_q),
        .pflag_q    (pflag_q),
        .pen_q      (pen_q),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    // Read multiplexer: unimplemented peripheral bits read as zero.
    always_comb begin
        rd_data = '0;
        unique case (rsel_e'(rd_sel))
            RSEL_CTRL:  rd_data = ctrl_q;
            RSEL_PFLAG: rd_data[ADC_BIT] = pflag_q;
            RSEL_PEN:   rd_data[ADC_BIT] = pen_q;
            RSEL_NONE:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/intr_flag_ctl_chk.sv
// Module: intr_flag_ctl_chk
// Assertion checker bound into intr_flag_ctl.
module intr_flag_ctl_chk #(
    parameter int              ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] VEC_INT = 10'h004,
    parameter logic [ADDR_W-1:0] VEC_RST = 10'h000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tmr_ovf,
    input logic              adc_done,
    input logic              int_ack,
    input logic              int_ret,
    input logic              irq_req,
    input logic [ADDR_W-1:0] irq_vector,
    input logic [7:0]        ctrl_q,
    input logic              pflag_q
);
    // R10
    gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !ctrl_q[7]);
    // R11
    gie_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ret && !int_ack) |=> ctrl_q[7]);
    // R5
    tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> ctrl_q[2]);
    // R6
    adc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_done |=> pflag_q);
    // R8
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctrl_q[7]);
    // R9
    vec_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector == VEC_INT));
    // R9
    vec_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vector == VEC_RST));
endmodule

bind intr_flag_ctl intr_flag_ctl_chk #(.ADDR_W(ADDR_W), .VEC_INT(VEC_INT), .VEC_RST(VEC_RST)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_ovf    (tmr_ovf),
    .adc_done   (adc_done),
    .int_ack    (int_ack),
    .int_ret    (int_ret),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .ctrl_q     (ctrl_q),
    .pflag_q    (pflag_q)
);

// File: tb/intr_flag_ctl_tb_top.sv
// Bench for intr_flag_ctl: a stimulus table walked step by step, then
// directed reset and vector checks.
module intr_flag_ctl_tb_top;
    typedef struct packed {
        logic       wr;
        logic [1:0] sel;
        logic [7:0] wd;
        logic [7:0] port;
        logic       rise;
        logic       tmr;
        logic       adc;
        logic       ack;
        logic       ret;
        logic       prd;
        logic [1:0] rsel;
        logic [7:0] exp_rd;
        logic       exp_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    // Fields: wr sel wd port rise tmr adc ack ret prd rsel exp_rd exp_irq req
    localparam vec_t VECS [NV] = '{
        '{1'b0,2'd0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,8'h04,1'b0,4'd5},  // R5 timer flag
        '{1'b1,2'd0,8'h24,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h24,1'b0,4'd2},  // R2 write-back
        '{1'b1,2'd0,8'hA4,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'hA4,1'b1,4'd8},  // R8 timer request
        '{1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,8'h24,1'b0,4'd10}, // R10 ack
        '{1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'hA4,1'b1,4'd11}, // R11 return
        '{1'b1,2'd0,8'h20,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h20,1'b0,4'd7},  // R7 sw clear
        '{1'b0,2'd0,8'h00,8'h04,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h20,1'b0,4'd4},  // R4 rise ignored
        '{1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h22,1'b0,4'd4},  // R4 fall taken
        '{1'b1,2'd0,8'h20,8'h04,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h22,1'b0,4'd7},  // R7 set beats clear
        '{1'b1,2'd0,8'h20,8'h04,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h20,1'b0,4'd7},  // R7 clear
        '{1'b0,2'd0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h20,1'b0,4'd4},  // R4 fall ignored
        '{1'b0,2'd0,8'h00,8'h01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h21,1'b0,4'd3},  // R3 bit0 change
        '{1'b1,2'd0,8'h20,8'h01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,8'h21,1'b0,4'd7},  // R7/R3 stale snapshot
        '{1'b1,2'd0,8'h20,8'h01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h20,1'b0,4'd3},  // R3 snapshot matches
        '{1'b0,2'd0,8'h00,8'h31,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h20,1'b0,4'd3},  // R3 unwatched bits
        '{1'b0,2'd0,8'h00,8'h31,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'd1,8'h40,1'b0,4'd6},  // R6 adc flag
        '{1'b1,2'd1,8'hFF,8'h31,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,8'h40,1'b0,4'd2},  // R2 pflag bits
        '{1'b1,2'd2,8'hFF,8'h31,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,8'h40,1'b0,4'd2},  // R2 pen bits
        '{1'b1,2'd0,8'h80,8'h31,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h80,1'b0,4'd8},  // R8 no periph gate
        '{1'b1,2'd0,8'hC0,8'h31,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'hC0,1'b1,4'd8},  // R8 periph gate open
        '{1'b1,2'd1,8'h00,8'h31,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,8'h00,1'b0,4'd8},  // R8 adc flag cleared
        '{1'b1,2'd0,8'h88,8'h33,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h89,1'b1,4'd3},  // R3 bit1 change
        '{1'b1,2'd0,8'h89,8'h33,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,8'h09,1'b0,4'd10}, // R10 ack wins
        '{1'b0,2'd0,8'h00,8'h33,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,8'h00,1'b0,4'd2}   // R2 select 3
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, port_rd, ext_rise_sel, tmr_ovf, adc_done, int_ack, int_ret;
    logic [1:0] wr_sel, rd_sel;
    logic [7:0] wr_data, rd_data, port_in;
    logic       irq_req;
    logic [9:0] irq_vector;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    intr_flag_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .port_in(port_in), .port_rd(port_rd),
        .ext_rise_sel(ext_rise_sel), .tmr_ovf(tmr_ovf), .adc_done(adc_done),
        .int_ack(int_ack), .int_ret(int_ret), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = 0; port_rd = 0; tmr_ovf = 0;
        adc_done = 0; int_ack = 0; int_ret = 0;
    endtask

    task automatic reset_checks();
        // R1 all registers zero, no request, reset vector
        for (int s = 0; s < 3; s++) begin
            rd_sel = 2'(s);
            #0.1;
            check("R1 rd", {8'h0, rd_data}, 16'h0);
        end
        check("R1 irq", {15'h0, irq_req}, 16'h0);
        check("R1 vector", {6'h0, irq_vector}, 16'h000);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rd_sel = 0; port_in = 0; ext_rise_sel = 0; rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        reset_checks();

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].wr; wr_sel = VECS[i].sel; wr_data = VECS[i].wd;
            port_in = VECS[i].port; ext_rise_sel = VECS[i].rise; tmr_ovf = VECS[i].tmr;
            adc_done = VECS[i].adc; int_ack = VECS[i].ack; int_ret = VECS[i].ret;
            port_rd = VECS[i].prd; rd_sel = VECS[i].rsel;
            @(posedge clk);
            #1;
            checks++;
            if (rd_data !== VECS[i].exp_rd || irq_req !== VECS[i].exp_irq) begin
                errors++;
                $display("FAIL R%0d step %0d actual rd %0h irq %0b expected rd %0h irq %0b",
                         VECS[i].req, i, rd_data, irq_req, VECS[i].exp_rd, VECS[i].exp_irq);
            end
            // R9 vector follows the request
            check("R9 vector", {6'h0, irq_vector}, irq_req ? 16'h004 : 16'h000);
        end

        // R11 return re-enables; pending pin-change gives vector 004h (R9)
        @(negedge clk);
        idle(); rd_sel = 0; int_ret = 1;
        @(posedge clk); #1;
        check("R11 rd", {8'h0, rd_data}, 16'h0089);
        check("R9 irq vector", {6'h0, irq_vector}, 16'h004);

        // R1 reset in the middle of activity clears everything
        @(negedge clk);
        idle(); rst_n = 0; port_in = 0;
        @(posedge clk); #1;
        @(negedge clk) rst_n = 1;
        reset_checks();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule